// File: doc/BRIEF.md
# Sticky General-Purpose Input Event Router

This block watches a bank of general-purpose input pins and turns qualified activity on them into latched event status and two level interrupt requests. Each raw pin first crosses into the block's clock domain through a multi-flop synchroniser. It is then compared against a per-pin polarity bit and sampled only on a sample strobe. A pin counts as qualified once it has been seen active on two consecutive strobes. The strobe itself is chosen by a power-state input. While the platform is running, the fast strobe is used; it is roughly a 33 MHz rate, so a pulse of about 60 ns is enough. While the platform is suspended, the slow 32.768 kHz strobe is used, so an input must stay active for about 61 µs.

Every pin except the lowest one owns a sticky status bit. The bit sets while its pin is qualified and stays set until software writes a one to clear it. If the pin is still qualified when it is cleared, the bit sets again at once, so the input behaves as level-triggered. The lowest pin has no sticky bit: its status position shows the live qualified level, and writes to clear it do nothing. A two-bit route field per pin steers the pin's status to the system-management interrupt output, to the system-control interrupt output, or to neither. No pin can ever reach both outputs.

Each pin runs its own qualifier state machine with three states. Q_IDLE means no active sample has been seen. Q_SEEN means one active sample has been seen. Q_QUAL means two or more consecutive active samples have been seen. On a strobe with the pin active, the machine takes the transition IDLE→SEEN, then SEEN→QUAL, and then QUAL→QUAL. On a strobe with the pin inactive, it takes any→IDLE. Without a strobe it holds its state.

Top module: `gpi_event_router`

## Requirements
- R1: Pin 0 has no sticky bit. stat_o[0] equals pin 0's qualified level, it falls when pin 0 stops qualifying, and clr_i[0] has no effect.
- R2: A status bit sets only after its pin has been active on two consecutive sample strobes. A single active strobe followed by an inactive one leaves the bit clear.
- R3: lvl_sel_i[i] picks the active level of pin i: 1 means active high and 0 means active low.
- R4: When run_i=1 the sample strobe is fast_stb_i and slow_stb_i is ignored. When run_i=0 the sample strobe is slow_stb_i and fast_stb_i is ignored. Without a strobe, qualification state does not change.
- R5: A set status bit of pins 1 to 15 stays set after its pin goes inactive, until it is cleared.
- R6: If the set condition and a clear of the same bit occur in the same cycle, set wins. Clearing a bit whose pin is still qualified leaves it set.
- R7: A pulse on clr_i[i] (i ≥ 1) clears status bit i in the next cycle when pin i is not qualified. Several bits can be cleared at once.
- R8: The route field of pin i is route_i[2i+1:2i], with code 00 meaning none, 01 meaning SMI, 10 meaning SCI and 11 meaning none. smi_o is the OR of all status bits routed to SMI, and sci_o is the OR of all status bits routed to SCI.
- R9: After reset all status bits are clear and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw_i | input | 16 | Raw asynchronous input pins |
| fast_stb_i | input | 1 | Sample strobe used while running |
| slow_stb_i | input | 1 | Sample strobe used while suspended |
| run_i | input | 1 | Power state: 1 running, 0 suspended |
| lvl_sel_i | input | 16 | Per-pin active level, 1 high and 0 low |
| route_i | input | 32 | Two-bit route code per pin |
| clr_i | input | 16 | Write-one-to-clear pulse per status bit |
| stat_o | output | 16 | Status: live level on bit 0, sticky bits above |
| smi_o | output | 1 | System-management interrupt request (level) |
| sci_o | output | 1 | System-control interrupt request (level) |

## Verification
The bench builds the block with its defaults: 16 pins, one non-sticky low pin and a two-stage synchroniser. With these values the bench can reach the boundary between the live pin 0 and the sticky pins, and it can exercise every route code, including the reserved code 11. The bench drives the strobes by hand, so it controls exactly how many samples a pin receives. This lets it show that one active sample does nothing and that two set the bit. Switching the power-state input shows that the strobe of the other power state is ignored.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_SMI  = 2'b01,
        RT_SCI  = 2'b10,
        RT_RSVD = 2'b11
    } route_e;

    typedef enum logic [1:0] {
        Q_IDLE = 2'b00,
        Q_SEEN = 2'b01,
        Q_QUAL = 2'b10
    } qual_e;

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[0] <= '0;
                    else        stg_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpi_qualifier.sv
module gpi_qualifier
    import gpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic pin_i,
    input  logic lvl_i,
    output logic qual_o
);
    qual_e state_q, state_d;
    logic  act;

    assign act = lvl_i ? pin_i : ~pin_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (stb_i) begin
            unique case (state_q)
                Q_IDLE:  state_d = act ? Q_SEEN : Q_IDLE;
                Q_SEEN:  state_d = act ? Q_QUAL : Q_IDLE;
                Q_QUAL:  state_d = act ? Q_QUAL : Q_IDLE;
                default: state_d = Q_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            Q_QUAL:  qual_o = 1'b1;
            default: qual_o = 1'b0;
        endcase
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(state_q)); // R4
    AST_INACTIVE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !act) |=> (state_q == Q_IDLE)); // R2
    AST_NO_SINGLE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_IDLE) |=> (state_q != Q_QUAL)); // R2
endmodule

// File: rtl/gpi_status.sv
module gpi_status #(
    parameter int N_PINS    = 16,
    parameter int STICKY_LO = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] qual_i,
    input  logic [N_PINS-1:0] clr_i,
    output logic [N_PINS-1:0] stat_o
);
    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_bit
            if (i < STICKY_LO) begin : g_live
                assign stat_o[i] = qual_i[i];
                AST_LIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                    $fell(qual_i[i]) |-> !stat_o[i]); // R1
            end else begin : g_sticky
                logic stat_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         stat_q <= 1'b0;
                    else if (qual_i[i]) stat_q <= 1'b1;
                    else if (clr_i[i])  stat_q <= 1'b0;
                end
                assign stat_o[i] = stat_q;

                AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                    qual_i[i] |=> stat_o[i]); // R6
                AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
                    (!qual_i[i] && !stat_o[i]) |=> !stat_o[i]); // R2
                AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    (stat_o[i] && !clr_i[i]) |=> stat_o[i]); // R5
            end
        end
    endgenerate
endmodule

// File: rtl/gpi_route.sv
module gpi_route
    import gpi_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic [N_PINS-1:0]   stat_i,
    input  logic [2*N_PINS-1:0] route_i,
    output logic                smi_o,
    output logic                sci_o
);
    logic [N_PINS-1:0] smi_hit;
    logic [N_PINS-1:0] sci_hit;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            route_e code;
            assign code = route_e'(route_i[2*i +: 2]);
            always_comb begin
                smi_hit[i] = 1'b0;
                sci_hit[i] = 1'b0;
                unique case (code)
                    RT_SMI:  smi_hit[i] = stat_i[i];
                    RT_SCI:  sci_hit[i] = stat_i[i];
                    RT_NONE: ;
                    RT_RSVD: ;
                    default: ;
                endcase
            end
        end
    endgenerate

    assign smi_o = |smi_hit;
    assign sci_o = |sci_hit;

    always_comb begin
        AST_EXCLUSIVE_ROUTE: assert ((smi_hit & sci_hit) == '0); // R8
    end
endmodule

// File: rtl/gpi_event_router.sv
module gpi_event_router #(
    parameter int N_PINS      = 16,
    parameter int STICKY_LO   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          pin_raw_i,
    input  logic                 fast_stb_i,
    input  logic                 slow_stb_i,
    input  logic                 run_i,
    input  logic [15:0]          lvl_sel_i,
    input  logic [31:0]          route_i,
    input  logic [15:0]          clr_i,
    output logic [15:0]          stat_o,
    output logic                 smi_o,
    output logic                 sci_o
);
    localparam int RW = 2 * N_PINS;

    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] qual;
    logic              samp_stb;

    assign samp_stb = run_i ? fast_stb_i : slow_stb_i;

    gpi_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw_i[N_PINS-1:0]),
        .q_o   (pin_sync)
    );

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_qual
            gpi_qualifier u_qual (
                .clk    (clk),
                .rst_n  (rst_n),
                .stb_i  (samp_stb),
                .pin_i  (pin_sync[i]),
                .lvl_i  (lvl_sel_i[i]),
                .qual_o (qual[i])
            );
        end
    endgenerate

    gpi_status #(.N_PINS(N_PINS), .STICKY_LO(STICKY_LO)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (qual),
        .clr_i  (clr_i[N_PINS-1:0]),
        .stat_o (stat_o)
    );

    gpi_route #(.N_PINS(N_PINS)) u_route (
        .stat_i  (stat_o),
        .route_i (route_i[RW-1:0]),
        .smi_o   (smi_o),
        .sci_o   (sci_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (stat_o[N_PINS-1:STICKY_LO] == '0)); // R9
endmodule

// File: tb/gpi_event_router_test.sv
module gpi_event_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_raw = '0;
    logic        fast_stb = 1'b0;
    logic        slow_stb = 1'b0;
    logic        run = 1'b1;
    logic [15:0] lvl_sel = 16'hFFFF;
    logic [31:0] route = '0;
    logic [15:0] clr = '0;
    logic [15:0] stat;
    logic        smi, sci;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] stat;
        logic        smi;
        logic        sci;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    gpi_event_router uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_raw_i  (pin_raw),
        .fast_stb_i (fast_stb),
        .slow_stb_i (slow_stb),
        .run_i      (run),
        .lvl_sel_i  (lvl_sel),
        .route_i    (route),
        .clr_i      (clr),
        .stat_o     (stat),
        .smi_o      (smi),
        .sci_o      (sci)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            wait (sb.size() > 0);
            #1;
            begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (stat !== e.stat || smi !== e.smi || sci !== e.sci) begin
                    errors++;
                    $display("FAIL %s: stat=%h smi=%b sci=%b expected stat=%h smi=%b sci=%b",
                             e.tag, stat, smi, sci, e.stat, e.smi, e.sci);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input logic [15:0] s,
                              input logic m, input logic c);
        exp_t e;
        @(negedge clk);
        e.tag = tag; e.stat = s; e.smi = m; e.sci = c;
        sb.push_back(e);
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_fast();
        @(negedge clk); fast_stb = 1'b1;
        @(negedge clk); fast_stb = 1'b0;
    endtask

    task automatic pulse_slow();
        @(negedge clk); slow_stb = 1'b1;
        @(negedge clk); slow_stb = 1'b0;
    endtask

    task automatic pulse_clr(input logic [15:0] m);
        @(negedge clk); clr = m;
        @(negedge clk); clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // routes: pin0 SMI, pin1 SMI, pin2 SCI, pin3 none, pin4 code 11, pin5 SCI, pin6 SMI
        route[1:0]   = 2'b01;
        route[3:2]   = 2'b01;
        route[5:4]   = 2'b10;
        route[7:6]   = 2'b00;
        route[9:8]   = 2'b11;
        route[11:10] = 2'b10;
        route[13:12] = 2'b01;
        settle(3);
        expect_out("R9 reset", 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;
        settle(2);
        expect_out("R9 after reset", 16'h0000, 1'b0, 1'b0);

        // R5 / R8: continuous fast strobe in run state
        fast_stb = 1'b1;
        pin_raw[1] = 1'b1;
        settle(6);
        expect_out("R8 pin1 to SMI", 16'h0002, 1'b1, 1'b0);
        pin_raw[1] = 1'b0;
        settle(6);
        expect_out("R5 sticky after pin low", 16'h0002, 1'b1, 1'b0);
        fast_stb = 1'b0;

        // R2: one active sample only
        pin_raw[2] = 1'b1; settle(4); pulse_fast();
        pin_raw[2] = 1'b0; settle(4); pulse_fast(); settle(3);
        expect_out("R2 single sample ignored", 16'h0002, 1'b1, 1'b0);
        pin_raw[2] = 1'b1; settle(4); pulse_fast(); settle(2); pulse_fast(); settle(3);
        expect_out("R2 two samples latch, R8 SCI", 16'h0006, 1'b1, 1'b1);

        // R6: clear while still qualified
        pin_raw[1] = 1'b1; settle(4); pulse_fast(); pulse_fast(); settle(2);
        pulse_clr(16'h0002); settle(2);
        expect_out("R6 clear while active relatches", 16'h0006, 1'b1, 1'b1);

        // R7: clear after inactive
        pin_raw[1] = 1'b0; settle(4); pulse_fast(); settle(2);
        pulse_clr(16'h0002); settle(1);
        expect_out("R7 clear pin1", 16'h0004, 1'b0, 1'b1);

        // R3: active-low pin5 (raw is low)
        lvl_sel[5] = 1'b0; settle(2); pulse_fast(); pulse_fast(); settle(2);
        expect_out("R3 active low latch", 16'h0024, 1'b0, 1'b1);
        pin_raw[5] = 1'b1; settle(4); pulse_fast(); settle(2);
        expect_out("R3 active low sticky", 16'h0024, 1'b0, 1'b1);

        // R8: code 11 routes nowhere
        pin_raw[4] = 1'b1; settle(4); pulse_fast(); pulse_fast(); settle(2);
        expect_out("R8 code 11 none", 16'h0034, 1'b0, 1'b1);

        // R1: pin0 live, not sticky
        pin_raw[0] = 1'b1; settle(4); pulse_fast(); pulse_fast(); settle(2);
        expect_out("R1 pin0 qualified", 16'h0035, 1'b1, 1'b1);
        pulse_clr(16'h0001); settle(1);
        expect_out("R1 pin0 clear ignored", 16'h0035, 1'b1, 1'b1);
        pin_raw[0] = 1'b0; settle(4); pulse_fast(); settle(2);
        expect_out("R1 pin0 drops", 16'h0034, 1'b0, 1'b1);

        // R4: suspended, fast strobe ignored
        run = 1'b0;
        fast_stb = 1'b1;
        pin_raw[6] = 1'b1;
        settle(10);
        expect_out("R4 fast ignored in suspend", 16'h0034, 1'b0, 1'b1);
        fast_stb = 1'b0;
        pulse_slow(); pulse_slow(); settle(2);
        expect_out("R4 slow strobe latches", 16'h0074, 1'b1, 1'b1);

        // R7: clear several bits at once
        pin_raw[4] = 1'b0; pin_raw[6] = 1'b0; settle(4); pulse_slow(); settle(2);
        pulse_clr(16'h0050); settle(1);
        expect_out("R7 multi clear", 16'h0024, 1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule